// File: doc/BRIEF.md
# Byte-Wide SCSI Block Mover

This block copies a run of bytes between a 16-bit-addressed memory and the data port of a SCSI core, so that a microcontroller does not have to move each byte itself. Software loads a byte count, a start address as two bytes, and a control byte, then sets the run bit. The engine then trades one byte per request/acknowledge handshake with the SCSI core and steps through memory until the count runs out.

The SCSI I/O phase line alone sets the direction. When that line is high, each byte offered by the core is written to memory. When it is low, each byte is read from memory and handed to the core. The engine does not follow bus phases, check parity or recover from errors. The microcontroller handles all of that. The only state the engine keeps is the remaining byte count and the current address. A status byte reports progress, the live direction and completion. An optional interrupt is raised when a transfer finishes.

Top module: `scsi_byte_dma`

## Requirements
- R1: After reset the status byte (register select 0) reads 0 with the I/O line low. `scsiAck`, `memRe`, `memWe` and `irq` are low.
- R2: A length register (select 1) value N in 1..255 moves exactly N bytes. The value 0 moves 256 bytes. Once the count is spent, further requests get no acknowledge.
- R3: The first byte uses address {select 3, select 2} (high byte, low byte). The address rises by one for each byte moved and wraps modulo 65536. `memAddr` holds the byte's address while `scsiAck` is high.
- R4: With `scsiIo` high, a request causes one `memWe` cycle that writes `scsiDin` to the current address, followed by an acknowledge.
- R5: With `scsiIo` low, a request causes one `memRe` cycle. The memory data, valid the cycle after `memRe`, is held on `scsiDout` while `scsiAck` is high.
- R6: `scsiAck` rises only after `scsiReq` has been seen high, and stays high until `scsiReq` falls. Exactly one byte is counted per handshake.
- R7: Status bit 2 shows the live `scsiIo` level: 1 means SCSI-to-memory and 0 means memory-to-SCSI.
- R8: Status bit 0 (in progress) is 1 from the cycle after a control write with bit 0 set until the last byte's handshake ends. In the cycle after `scsiReq` falls on the last byte, bit 0 reads 0 and status bit 3 (complete) reads 1.
- R9: `irq` equals status bit 3 ANDed with control bit 1 (interrupt enable). Reading the status byte with `regRd` clears bit 3 and `irq` from the next cycle. Starting a new transfer also clears them.
- R10: A control write with bit 0 clear during a transfer stops it at once: bit 0 reads 0, bit 3 stays 0, `irq` stays low, and later requests get no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 2 | Register select: 0 control/status, 1 length, 2 address low, 3 address high |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (side effect on status only) |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data, combinational from regSel |
| scsiIo | input | 1 | SCSI I/O phase line, high = SCSI-to-memory |
| scsiReq | input | 1 | Byte request from the SCSI core |
| scsiAck | output | 1 | Byte acknowledge to the SCSI core |
| scsiDin | input | 8 | Byte from the SCSI core |
| scsiDout | output | 8 | Byte to the SCSI core |
| memAddr | output | 16 | Memory address |
| memRe | output | 1 | Memory read enable, data returned next cycle |
| memWe | output | 1 | Memory write enable |
| memWdata | output | 8 | Memory write data |
| memRdata | input | 8 | Memory read data |
| irq | output | 1 | Completion interrupt |

## Verification
In the inbound direction, the memory write falls in the same cycle that the request is first seen, and the acknowledge follows one edge later. In the outbound direction, the read enable comes in that same cycle, the memory data is captured one edge later, and the acknowledge comes on the edge after that. The bench therefore drives requests on falling edges and waits for the acknowledge to appear before it samples `memAddr` and `scsiDout`. On the last byte, the bench samples the status on the falling edge right after it drops the request, because busy clears and complete sets on that one rising edge. Read-clear effects are checked one falling edge after the `regRd` cycle.

// File: rtl/dmaPkg.sv
package dmaPkg;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_LEN  = 2'd1;
  localparam logic [1:0] SEL_ALO  = 2'd2;
  localparam logic [1:0] SEL_AHI  = 2'd3;

  localparam int BIT_BUSY  = 0;
  localparam int BIT_IRQEN = 1;
  localparam int BIT_DIR   = 2;
  localparam int BIT_DONE  = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_RDATA = 2'd2,
    ST_ACK   = 2'd3
  } dmaState_t;

  typedef struct packed {
    logic loadXfer;
    logic stepByte;
    logic latchRd;
    logic finish;
    logic abort;
  } dmaStrobes_t;
endpackage

// File: rtl/dmaCtrl.sv
module dmaCtrl
  import dmaPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startCmd,
  input  logic        stopCmd,
  input  logic        scsiReq,
  input  logic        scsiIo,
  input  logic        lastByte,
  output dmaStrobes_t strb,
  output logic        busy,
  output logic        scsiAck,
  output logic        memWe,
  output logic        memRe
);
  dmaState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    memWe     = 1'b0;
    memRe     = 1'b0;
    if (state == ST_IDLE) begin
      if (startCmd) begin
        strb.loadXfer = 1'b1;
        nextState     = ST_WAIT;
      end
    end else if (stopCmd) begin
      strb.abort = 1'b1;
      nextState  = ST_IDLE;
    end else begin
      unique case (state)
        ST_WAIT: begin
          if (scsiReq) begin
            if (scsiIo) begin
              memWe     = 1'b1;
              nextState = ST_ACK;
            end else begin
              memRe     = 1'b1;
              nextState = ST_RDATA;
            end
          end
        end
        ST_RDATA: begin
          strb.latchRd = 1'b1;
          nextState    = ST_ACK;
        end
        ST_ACK: begin
          if (!scsiReq) begin
            strb.stepByte = 1'b1;
            if (lastByte) begin
              strb.finish = 1'b1;
              nextState   = ST_IDLE;
            end else begin
              nextState = ST_WAIT;
            end
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  assign busy    = (state != ST_IDLE);
  assign scsiAck = (state == ST_ACK);
endmodule

// File: rtl/dmaDatapath.sv
module dmaDatapath
  import dmaPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              scsiIo,
  input  logic [DATA_W-1:0] memRdata,
  input  dmaStrobes_t       strb,
  input  logic              busy,
  output logic [ADDR_W-1:0] curAddr,
  output logic [DATA_W-1:0] outData,
  output logic              lastByte,
  output logic              startCmd,
  output logic              stopCmd,
  output logic              irqOut
);
  localparam int CNT_W = LEN_W + 1;
  localparam int HI_W  = ADDR_W - DATA_W;
  localparam logic [CNT_W-1:0] FULL_CNT = {1'b1, {LEN_W{1'b0}}};
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic [LEN_W-1:0]  lenReg;
  logic [DATA_W-1:0] addrLo;
  logic [HI_W-1:0]   addrHi;
  logic              irqEn;
  logic              doneFlag;
  logic [CNT_W-1:0]  count;

  logic ctrlWr, statusRd;
  assign ctrlWr   = regWr && (regSel == SEL_CTRL);
  assign statusRd = regRd && (regSel == SEL_CTRL);
  assign startCmd = ctrlWr && regWdata[BIT_BUSY] && !busy;
  assign stopCmd  = ctrlWr && !regWdata[BIT_BUSY] && busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenReg <= '0;
      addrLo <= '0;
      addrHi <= '0;
      irqEn  <= 1'b0;
    end else if (regWr) begin
      unique case (regSel)
        SEL_CTRL: irqEn  <= regWdata[BIT_IRQEN];
        SEL_LEN:  lenReg <= regWdata[LEN_W-1:0];
        SEL_ALO:  addrLo <= regWdata;
        SEL_AHI:  addrHi <= regWdata[HI_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) doneFlag <= 1'b0;
    else if (strb.finish) doneFlag <= 1'b1;
    else if (strb.loadXfer || statusRd) doneFlag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      count   <= '0;
    end else if (strb.loadXfer) begin
      curAddr <= {addrHi, addrLo};
      count   <= (lenReg == '0) ? FULL_CNT : CNT_W'(lenReg);
    end else if (strb.stepByte) begin
      curAddr <= curAddr + 1'b1;
      count   <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) outData <= '0;
    else if (strb.latchRd) outData <= memRdata;
  end

  assign lastByte = (count == ONE_CNT);
  assign irqOut   = doneFlag && irqEn;

  always_comb begin
    regRdata = '0;
    unique case (regSel)
      SEL_CTRL: begin
        regRdata[BIT_BUSY]  = busy;
        regRdata[BIT_IRQEN] = irqEn;
        regRdata[BIT_DIR]   = scsiIo;
        regRdata[BIT_DONE]  = doneFlag;
      end
      SEL_LEN: regRdata[LEN_W-1:0] = lenReg;
      SEL_ALO: regRdata = addrLo;
      SEL_AHI: regRdata[HI_W-1:0] = addrHi;
      default: regRdata = '0;
    endcase
  end
endmodule

// File: rtl/scsi_byte_dma.sv
module scsi_byte_dma
  import dmaPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              scsiIo,
  input  logic              scsiReq,
  output logic              scsiAck,
  input  logic [DATA_W-1:0] scsiDin,
  output logic [DATA_W-1:0] scsiDout,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              irq
);
  dmaStrobes_t strb;
  logic busy, lastByte, startCmd, stopCmd;

  dmaCtrl ctrl (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .stopCmd(stopCmd),
    .scsiReq(scsiReq), .scsiIo(scsiIo), .lastByte(lastByte),
    .strb(strb), .busy(busy), .scsiAck(scsiAck), .memWe(memWe), .memRe(memRe)
  );

  dmaDatapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) dpath (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .scsiIo(scsiIo),
    .memRdata(memRdata), .strb(strb), .busy(busy), .curAddr(memAddr),
    .outData(scsiDout), .lastByte(lastByte), .startCmd(startCmd),
    .stopCmd(stopCmd), .irqOut(irq)
  );

  assign memWdata = scsiDin;
endmodule

// File: rtl/scsi_byte_dma_check.sv
module scsi_byte_dma_check (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] regSel,
  input logic       regWr,
  input logic [7:0] regWdata,
  input logic       scsiIo,
  input logic       scsiReq,
  input logic       scsiAck,
  input logic       memRe,
  input logic       memWe
);
  assert_ack_after_req_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(scsiAck) |-> $past(scsiReq));

  assert_ack_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (scsiAck && scsiReq && !(regWr && regSel == 2'd0 && !regWdata[0])) |=> scsiAck);

  assert_mem_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));

  assert_write_inbound_R4: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (scsiIo && scsiReq && !scsiAck));

  assert_read_outbound_R5: assert property (@(posedge clk) disable iff (!rstN)
    memRe |-> (!scsiIo && scsiReq && !scsiAck));

  assert_ack_after_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    memRe |=> !scsiAck);
endmodule

bind scsi_byte_dma scsi_byte_dma_check chk (
  .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regWdata(regWdata),
  .scsiIo(scsiIo), .scsiReq(scsiReq), .scsiAck(scsiAck), .memRe(memRe), .memWe(memWe)
);

// File: tb/scsi_byte_dma_test.sv
`timescale 1ns/1ps
module scsi_byte_dma_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [7:0]  regWdata = 8'd0;
  logic [7:0]  regRdata;
  logic        scsiIo = 1'b0, scsiReq = 1'b0, scsiAck;
  logic [7:0]  scsiDin = 8'd0, scsiDout;
  logic [15:0] memAddr;
  logic        memRe, memWe;
  logic [7:0]  memWdata, memRdata;
  logic        irq;

  int total = 0, fails = 0;
  bit finished = 0;
  logic [7:0] mem [256];

  always #4 clk = ~clk;

  scsi_byte_dma uut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .scsiIo(scsiIo), .scsiReq(scsiReq),
    .scsiAck(scsiAck), .scsiDin(scsiDin), .scsiDout(scsiDout), .memAddr(memAddr),
    .memRe(memRe), .memWe(memWe), .memWdata(memWdata), .memRdata(memRdata), .irq(irq)
  );

  always @(posedge clk) begin
    if (memRe) memRdata <= mem[memAddr[7:0]];
    if (memWe) mem[memAddr[7:0]] <= memWdata;
  end

  task automatic check(input string req, input int actual, input int expected);
    total++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    regSel = sel; regWdata = data; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0; regSel = 2'd0;
  endtask

  task automatic statusRead(output logic [7:0] value);
    @(negedge clk);
    regSel = 2'd0; regRd = 1'b1;
    #1 value = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  function automatic logic [7:0] pattern(input int i, input int seed);
    return 8'((i * 7 + seed * 13 + 5) & 255);
  endfunction

  task automatic noAckCheck(input string req);
    int seen = 0;
    scsiReq = 1'b1;
    repeat (5) begin
      @(negedge clk);
      if (scsiAck) seen++;
    end
    scsiReq = 1'b0;
    check(req, seen, 0);
  endtask

  task automatic moveBytes(input int count, input int startIdx, input logic [15:0] base,
                           input logic dir, input int seed, input int total_n,
                           input logic ien);
    for (int i = startIdx; i < startIdx + count; i++) begin
      logic [15:0] a = base + 16'(i);
      @(negedge clk);
      scsiDin = pattern(i, seed);
      scsiReq = 1'b1;
      @(negedge clk);
      while (!scsiAck) @(negedge clk);
      check("R3 address at ack", memAddr, a);
      if (!dir) check("R5 byte to SCSI", scsiDout, pattern(i, seed));
      if (i == total_n - 1) begin
        check("R8 busy before last release", regRdata[0], 1);
        check("R8 done before last release", regRdata[3], 0);
      end
      scsiReq = 1'b0;
      @(negedge clk);
      check("R6 ack drops after release", scsiAck, 0);
      if (i == total_n - 1) begin
        check("R8 busy clear after last", regRdata[0], 0);
        check("R8 done set after last", regRdata[3], 1);
        check("R9 irq follows enable", irq, ien);
      end
    end
  endtask

  task automatic runXfer(input logic [7:0] lenCode, input logic [15:0] base,
                         input logic dir, input logic ien, input int seed);
    int n = (lenCode == 8'd0) ? 256 : int'(lenCode);
    logic [7:0] st;
    scsiIo = dir;
    for (int k = 0; k < 256; k++) mem[k] = 8'hA5;
    if (!dir) for (int i = 0; i < n; i++) mem[8'(base + 16'(i))] = pattern(i, seed);
    regWrite(2'd1, lenCode);
    regWrite(2'd2, base[7:0]);
    regWrite(2'd3, base[15:8]);
    regWrite(2'd0, {6'd0, ien, 1'b1});
    check("R8 busy after start", regRdata[0], 1);
    check("R9 done cleared by start", regRdata[3], 0);
    moveBytes(n, 0, base, dir, seed, n, ien);
    if (dir) begin
      int bad = 0;
      for (int i = 0; i < n; i++)
        if (mem[8'(base + 16'(i))] !== pattern(i, seed)) bad++;
      check("R4 memory written", bad, 0);
    end
    noAckCheck("R2 no ack after count");
    statusRead(st);
    check("R7 R8 R9 status after xfer", st, {4'd0, 1'b1, dir, ien, 1'b0});
    @(negedge clk);
    check("R9 irq clear after read", irq, 0);
    check("R9 done clear after read", regRdata[3], 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] st;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 status after reset", regRdata, 0);
    check("R1 ack after reset", scsiAck, 0);
    check("R1 memRe after reset", memRe, 0);
    check("R1 memWe after reset", memWe, 0);
    check("R1 irq after reset", irq, 0);

    scsiIo = 1'b1;
    #1 check("R7 direction high", regRdata[2], 1);
    scsiIo = 1'b0;
    #1 check("R7 direction low", regRdata[2], 0);

    for (int len = 1; len <= 24; len++) begin
      runXfer(8'(len), 16'h1200 + 16'(len * 37), 1'b0, len[0], len);
      runXfer(8'(len), 16'h8000 + 16'(len * 53), 1'b1, ~len[0], len + 100);
    end
    runXfer(8'd255, 16'h00F0, 1'b1, 1'b1, 7);
    runXfer(8'd0, 16'hFFF8, 1'b0, 1'b1, 9);
    runXfer(8'd0, 16'hFF80, 1'b1, 1'b0, 11);

    // R10 abort mid-transfer
    scsiIo = 1'b0;
    for (int k = 0; k < 256; k++) mem[k] = pattern(k, 3);
    regWrite(2'd1, 8'd10);
    regWrite(2'd2, 8'h00);
    regWrite(2'd3, 8'h40);
    regWrite(2'd0, 8'h03);
    moveBytes(3, 0, 16'h4000, 1'b0, 3, 10, 1'b1);
    regWrite(2'd0, 8'h00);
    check("R10 busy clear on abort", regRdata[0], 0);
    check("R10 done stays clear", regRdata[3], 0);
    check("R10 irq stays low", irq, 0);
    noAckCheck("R10 no ack after abort");

    // R9 start clears a pending done
    runXfer(8'd2, 16'h0300, 1'b1, 1'b1, 4);
    regWrite(2'd1, 8'd1);
    regWrite(2'd0, 8'h03);
    moveBytes(1, 0, 16'h0300, 1'b1, 5, 1, 1'b1);
    regWrite(2'd0, 8'h03);
    check("R9 start clears done", regRdata[3], 0);
    check("R9 start clears irq", irq, 0);
    regWrite(2'd0, 8'h00);
    statusRead(st);
    check("R10 idle after stop", st[0], 0);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule